// File: doc/BRIEF.md
# Speed-Grade Binning Controller

This block sorts a device under test into a frequency bin by running the path-delay test more than once. It holds a parameter-built table of capture gaps, ordered from the tightest gap (the highest rated frequency) to the loosest. After a start request it issues a test with the tightest gap and waits for the tester's verdict. On a pass it records the index of the gap in use as the bin. On a fail it moves to the next looser gap and issues the test again. The first passing gap therefore marks the fastest clock rate the device sustained.

If every gap in the table fails, the device is rejected. The table's contents come from a base, a step and a growth mode, which are all parameters. An elaboration check refuses any table that does not strictly increase, because a gap that does not loosen cannot separate two bins. The controller drives the gap value and a test request to the tester. The tester returns a done strobe with a pass flag. When a binning run finishes, the controller reports the bin index, a reject flag and a one-cycle done pulse.

Top module: `speed_bin_ctrl`

## Requirements
- R1: After reset, `tst_req` is 0, `bin_done` is 0, `bin_reject` is 0, `bin_idx` is 0, and `cap_gap` shows table entry 0.
- R2: With the default parameters (linear mode, base 40, step 8, eight entries), entry i of the gap table is 40 + 8*i, so the table runs 40, 48, ..., 96. Any parameter set whose table is not strictly increasing is refused at elaboration.
- R3: A `run_go` pulse sampled while idle raises `tst_req` in the next cycle, with `cap_gap` equal to entry 0.
- R4: Once raised, `tst_req` stays high and `cap_gap` stays unchanged until a cycle in which `tst_done` is high.
- R5: `tst_pass` is sampled only in a cycle where `tst_req` and `tst_done` are both high. If it is 1 while entry i is applied, then in the next cycle `bin_done` is 1, `bin_idx` equals i, `bin_reject` is 0 and `tst_req` is 0.
- R6: If a test fails at entry i and i is below the last entry, then `tst_req` is 0 for exactly one cycle. After that, `tst_req` is high again with `cap_gap` equal to entry i+1.
- R7: If the test also fails at the last entry (index 7 by default), then in the next cycle `bin_done` is 1, `bin_reject` is 1 and `bin_idx` equals 7.
- R8: A `run_go` pulse during a binning run has no effect on the gap sequence or on the result.
- R9: `bin_done` is high for exactly one cycle per run. `bin_idx` and `bin_reject` keep their values until the next run completes.
- R10: A `tst_done` strobe while the controller is idle produces no `bin_done` and no `tst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_go | input | 1 | Start a binning run (sampled while idle) |
| cap_gap | output | GAP_W | Capture gap of the current attempt |
| tst_req | output | 1 | Test request to the tester, held until done |
| tst_done | input | 1 | Tester finished the current attempt |
| tst_pass | input | 1 | Verdict of the attempt, valid with tst_done |
| bin_idx | output | $clog2(N_GAPS) | Assigned bin, 0 is fastest |
| bin_reject | output | 1 | Device failed every gap |
| bin_done | output | 1 | One-cycle pulse when a run ends |

## Verification
The hardest situation to reach is a device that fails at every gap but the last, or at every gap. The bench must also make a stray start or a stray pass flag arrive in exactly the cycles where it could corrupt the sequence: during a held request and during the single idle cycle between attempts. The bench models the device as a hidden delay that passes whenever the applied gap is at least that delay. Directed delays sit just below, on and just above the table's edges, and random delays span the whole range. Random tester latencies and randomly timed start pulses land in both the held-request cycles and the gap-step cycles.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

   typedef enum logic [1:0] {
      SGB_IDLE = 2'd0,
      SGB_TEST = 2'd1,
      SGB_STEP = 2'd2
   } sgb_state_t;

   localparam int SGB_LINEAR = 0;
   localparam int SGB_DOUBLING = 1;

   // Gap value of table entry i for the chosen growth mode.
   function automatic longint sgb_gap_at(int kind, longint base, longint step, int i);
      if (kind == SGB_LINEAR) return base + step * i;
      return base + step * ((longint'(1) << i) - 1);
   endfunction

endpackage

// File: rtl/sgb_gap_table.sv
module sgb_gap_table
   import sgb_pkg::*;
#(
   parameter int N_GAPS = 8,
   parameter int GAP_W = 16,
   parameter int TABLE_KIND = SGB_LINEAR,
   parameter int GAP_BASE = 40,
   parameter int GAP_STEP = 8,
   localparam int IDX_W = $clog2(N_GAPS)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [GAP_W-1:0] gap
);

   logic [GAP_W-1:0] entries [N_GAPS];

   if (N_GAPS < 2) begin : g_bad_depth
      $error("sgb_gap_table: N_GAPS must be at least 2");
   end
   if (TABLE_KIND != SGB_LINEAR && TABLE_KIND != SGB_DOUBLING) begin : g_bad_kind
      $error("sgb_gap_table: unknown TABLE_KIND");
   end
   if (sgb_gap_at(TABLE_KIND, GAP_BASE, GAP_STEP, N_GAPS-1) >= (longint'(1) << GAP_W))
   begin : g_bad_width
      $error("sgb_gap_table: last gap does not fit GAP_W");
   end
   if (GAP_BASE < 0) begin : g_bad_base
      $error("sgb_gap_table: GAP_BASE must not be negative");
   end

   for (genvar i = 0; i < N_GAPS; i++) begin : g_entry
      // R2
      if (i > 0) begin : g_mono
         if (sgb_gap_at(TABLE_KIND, GAP_BASE, GAP_STEP, i) <=
             sgb_gap_at(TABLE_KIND, GAP_BASE, GAP_STEP, i-1)) begin : g_not_rising
            $error("sgb_gap_table: gap table is not strictly increasing");
         end
      end
      if (TABLE_KIND == SGB_LINEAR) begin : g_lin
         assign entries[i] = GAP_W'(GAP_BASE + GAP_STEP * i);
      end else begin : g_dbl
         assign entries[i] = GAP_W'(sgb_gap_at(SGB_DOUBLING, GAP_BASE, GAP_STEP, i));
      end
   end

   assign gap = entries[idx];

endmodule

// File: rtl/sgb_step_counter.sv
module sgb_step_counter #(
   parameter int N_GAPS = 8,
   localparam int IDX_W = $clog2(N_GAPS),
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_GAPS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clear) begin
         idx <= '0;
      end else if (advance && idx != LAST) begin
         idx <= idx + 1'b1;
      end
   end

   assign at_last = (idx == LAST);

   // R6
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && !at_last) |=> (idx == $past(idx) + 1'b1));

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last && !clear) |=> at_last);

endmodule

// File: rtl/sgb_sequencer.sv
module sgb_sequencer
   import sgb_pkg::*;
#(
   parameter int N_GAPS = 8,
   localparam int IDX_W = $clog2(N_GAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_go,
   input  logic             tst_done,
   input  logic             tst_pass,
   input  logic [IDX_W-1:0] idx,
   input  logic             at_last,
   output logic             clear,
   output logic             advance,
   output logic             tst_req,
   output logic             bin_done,
   output logic [IDX_W-1:0] bin_idx,
   output logic             bin_reject
);

   sgb_state_t state;

   logic verdict;
   assign verdict = (state == SGB_TEST) && tst_done;

   assign clear   = (state == SGB_IDLE) && run_go;
   assign advance = verdict && !tst_pass && !at_last;
   assign tst_req = (state == SGB_TEST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SGB_IDLE;
         bin_done   <= 1'b0;
         bin_idx    <= '0;
         bin_reject <= 1'b0;
      end else begin
         bin_done <= 1'b0;
         unique case (state)
            SGB_IDLE: begin
               if (run_go) state <= SGB_TEST;
            end
            SGB_TEST: begin
               if (tst_done) begin
                  if (tst_pass) begin
                     bin_idx    <= idx;
                     bin_reject <= 1'b0;
                     bin_done   <= 1'b1;
                     state      <= SGB_IDLE;
                  end else if (at_last) begin
                     bin_idx    <= idx;
                     bin_reject <= 1'b1;
                     bin_done   <= 1'b1;
                     state      <= SGB_IDLE;
                  end else begin
                     state <= SGB_STEP;
                  end
               end
            end
            SGB_STEP: begin
               state <= SGB_TEST;
            end
            default: state <= SGB_IDLE;
         endcase
      end
   end

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_req && !tst_done) |=> tst_req);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bin_done |=> !bin_done);

   // R5
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bin_done |-> ($past(tst_done) && $past(tst_req)));

   // R10
   idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tst_req && !bin_done) |=> !bin_done);

   // R6
   step_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_req && tst_done && !tst_pass && !at_last) |=> (!tst_req ##1 tst_req));

endmodule

// File: rtl/speed_bin_ctrl.sv
module speed_bin_ctrl
   import sgb_pkg::*;
#(
   parameter int N_GAPS = 8,
   parameter int GAP_W = 16,
   parameter int TABLE_KIND = SGB_LINEAR,
   parameter int GAP_BASE = 40,
   parameter int GAP_STEP = 8,
   localparam int IDX_W = $clog2(N_GAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_go,
   output logic [GAP_W-1:0] cap_gap,
   output logic             tst_req,
   input  logic             tst_done,
   input  logic             tst_pass,
   output logic [IDX_W-1:0] bin_idx,
   output logic             bin_reject,
   output logic             bin_done
);

   logic [IDX_W-1:0] cur_idx;
   logic             at_last;
   logic             clear;
   logic             advance;

   sgb_gap_table #(
      .N_GAPS(N_GAPS), .GAP_W(GAP_W), .TABLE_KIND(TABLE_KIND),
      .GAP_BASE(GAP_BASE), .GAP_STEP(GAP_STEP)
   ) u_table (
      .idx(cur_idx),
      .gap(cap_gap)
   );

   sgb_step_counter #(.N_GAPS(N_GAPS)) u_count (
      .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
      .idx(cur_idx), .at_last(at_last)
   );

   sgb_sequencer #(.N_GAPS(N_GAPS)) u_seq (
      .clk(clk), .rst_n(rst_n), .run_go(run_go),
      .tst_done(tst_done), .tst_pass(tst_pass),
      .idx(cur_idx), .at_last(at_last),
      .clear(clear), .advance(advance), .tst_req(tst_req),
      .bin_done(bin_done), .bin_idx(bin_idx), .bin_reject(bin_reject)
   );

   // R4
   gap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_req && !tst_done) |=> $stable(cap_gap));

   // R7
   reject_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bin_reject |-> (bin_idx == IDX_W'(N_GAPS - 1)));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_req && !tst_done && run_go) |=> (tst_req && $stable(cap_gap)));

endmodule

// File: tb/tb_speed_bin_ctrl.sv
module tb_speed_bin_ctrl;

   localparam int N = 8;
   localparam int GW = 16;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_go = 1'b0;
   logic tst_done = 1'b0;
   logic tst_pass = 1'b0;
   logic [GW-1:0] cap_gap;
   logic tst_req;
   logic [IW-1:0] bin_idx;
   logic bin_reject;
   logic bin_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   speed_bin_ctrl dut (
      .clk(clk), .rst_n(rst_n), .run_go(run_go), .cap_gap(cap_gap),
      .tst_req(tst_req), .tst_done(tst_done), .tst_pass(tst_pass),
      .bin_idx(bin_idx), .bin_reject(bin_reject), .bin_done(bin_done)
   );

   function automatic int exp_gap(int i);
      return 40 + 8 * i;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One binning run for a device whose path delay is dly.
   task automatic run_device(int dly, bit poke);
      int exp_bin;
      bit exp_rej;
      exp_bin = N - 1;
      exp_rej = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (exp_gap(i) >= dly) begin
            exp_bin = i;
            exp_rej = 1'b0;
            break;
         end
      end
      @(negedge clk) run_go = 1'b1;
      @(negedge clk) run_go = 1'b0;
      for (int a = 0; a < N; a++) begin
         int lat;
         bit pass;
         chk(tst_req == 1'b1, a == 0 ? "R3 req" : "R6 req", int'(tst_req), 1);
         chk(int'(cap_gap) == exp_gap(a), a == 0 ? "R3 gap" : "R6 gap",
             int'(cap_gap), exp_gap(a));
         lat = $urandom_range(0, 4);
         for (int k = 0; k < lat; k++) begin
            tst_pass = 1'($urandom);
            run_go = poke && (k == 0);
            @(negedge clk);
            run_go = 1'b0;
            chk(tst_req == 1'b1, "R4 held", int'(tst_req), 1);
            chk(int'(cap_gap) == exp_gap(a), "R4 gap stable", int'(cap_gap), exp_gap(a));
            chk(bin_done == 1'b0, "R5 no early done", int'(bin_done), 0);
         end
         pass = (exp_gap(a) >= dly);
         tst_done = 1'b1;
         tst_pass = pass;
         @(negedge clk);
         tst_done = 1'b0;
         tst_pass = 1'b0;
         if (pass) begin
            chk(bin_done == 1'b1, "R5 done", int'(bin_done), 1);
            chk(int'(bin_idx) == exp_bin, "R5 bin", int'(bin_idx), exp_bin);
            chk(bin_reject == 1'b0, "R5 reject", int'(bin_reject), 0);
            chk(tst_req == 1'b0, "R5 req low", int'(tst_req), 0);
            break;
         end else if (a == N - 1) begin
            chk(bin_done == 1'b1, "R7 done", int'(bin_done), 1);
            chk(bin_reject == 1'b1, "R7 reject", int'(bin_reject), int'(exp_rej));
            chk(int'(bin_idx) == N - 1, "R7 bin", int'(bin_idx), N - 1);
         end else begin
            chk(tst_req == 1'b0, "R6 gap cycle", int'(tst_req), 0);
            chk(bin_done == 1'b0, "R6 no done", int'(bin_done), 0);
            run_go = poke;
            @(negedge clk);
            run_go = 1'b0;
         end
      end
      @(negedge clk);
      chk(bin_done == 1'b0, "R9 single pulse", int'(bin_done), 0);
      chk(int'(bin_idx) == exp_bin, "R9 bin hold", int'(bin_idx), exp_bin);
      chk(bin_reject == exp_rej, "R9 reject hold", int'(bin_reject), int'(exp_rej));
      repeat (2) @(negedge clk);
      chk(int'(bin_idx) == exp_bin, "R9 bin hold later", int'(bin_idx), exp_bin);
   endtask

   initial begin
      void'($urandom(32'd1995));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tst_req == 1'b0, "R1 req", int'(tst_req), 0);
      chk(bin_done == 1'b0, "R1 done", int'(bin_done), 0);
      chk(bin_reject == 1'b0, "R1 reject", int'(bin_reject), 0);
      chk(bin_idx == '0, "R1 bin", int'(bin_idx), 0);
      chk(int'(cap_gap) == exp_gap(0), "R1 gap", int'(cap_gap), exp_gap(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R10 stray done strobe while idle
      tst_done = 1'b1;
      tst_pass = 1'b1;
      @(negedge clk);
      tst_done = 1'b0;
      tst_pass = 1'b0;
      chk(bin_done == 1'b0, "R10 no done", int'(bin_done), 0);
      chk(tst_req == 1'b0, "R10 no req", int'(tst_req), 0);
      @(negedge clk);
      chk(bin_done == 1'b0, "R10 still idle", int'(bin_done), 0);
      // R2 table edges, directed
      run_device(40, 1'b0);
      run_device(41, 1'b0);
      run_device(96, 1'b1);
      run_device(97, 1'b1);
      run_device(300, 1'b0);
      run_device(64, 1'b1);
      run_device(0, 1'b1);
      // R8 random starts during runs, random delays
      for (int r = 0; r < 40; r++) begin
         run_device(int'($urandom_range(20, 110)), 1'($urandom));
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule